// File: doc/BRIEF.md
# I2C Master Transaction Offload Engine

This block runs a complete I2C master transfer of one to eight bytes with no processor work per byte. Software fills two 32-bit transmit words and writes a single control word. That word holds the target address, the direction, the byte count and a go bit. The engine then produces START, the address phase (7-bit or 10-bit), the data bytes with their acknowledge slots, and STOP. It drives two open-drain lines through pull-low enables.

On a read, the received bytes are packed into two 32-bit receive words. When the bus is released, the engine records success or failure in a status bit, sets a completion cause bit and, if the mask bit allows it, asserts an interrupt. Software acknowledges by writing zero to the cause and control words.

Bit timing is built from quarter periods of the system clock. The quarter length is taken from a timing word, or from a parameter when that word is zero.

Top module: `i2c_xfer_engine`

## Requirements
- R1: After reset every register reads zero, both line drivers are released and `irq` is low.
- R2: The register word index on `reg_addr` decodes as follows: 0 and 1 are transmit low and high, 2 and 3 are receive low and high (read-only), 4 is control, 5 is status, 6 is cause, 7 is mask and 8 is timing. Transmit, mask and timing read back what was written; control reads back its bits [19:0].
- R3: A control write with bit 19 set while idle starts a transfer. With bit 1 clear it is a write: START, the byte {addr[6:0], 0} with addr taken from bits [11:2], then N = bits[15:13]+1 data bytes, then STOP. Data byte i comes from transmit word i/4 at bits [8*(i%4)+7 : 8*(i%4)], byte 0 first, and each byte is sent MSB first.
- R4: With bit 1 set the transfer is a read. The address byte ends in 1 and N = bits[18:16]+1 bytes are received. Received byte i lands in receive word i/4 at bits [8*(i%4)+7 : 8*(i%4)], and unused bytes read zero. The master acknowledges every byte except the last, which it leaves unacknowledged (SDA high).
- R5: With bit 12 set, the address phase is two bytes: {11110, addr[9:8], dir} followed by addr[7:0].
- R6: A missing acknowledge on any address byte or written data byte ends the transfer with STOP straight after that byte, and status bit 0 is set. A transfer that completes cleanly leaves status bit 0 at zero.
- R7: Every finished transfer sets cause bit 0. `irq` equals cause bit 0 AND mask bit 0. A write to the cause word loads bit 0 from the written data, so writing 0 clears it.
- R8: While a transfer runs, writes to control and to the transmit words are ignored: the readback is unchanged and no second transfer starts.
- R9: Each bit slot holds SCL high for two quarter periods. A quarter lasts timing[15:0] clocks when that field is nonzero, and the `DEF_QUARTER` parameter otherwise.
- R10: Inside the bit slots, the SDA driver changes only while SCL is held low. Both drivers are released whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Completion interrupt |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The per-cycle properties cover the line discipline: both drivers are released while idle, and the SDA driver holds still while SCL is high inside a bit slot. They also check that the control word is frozen while a transfer runs, that completion always leaves the cause bit set, and that `irq` never appears with the mask bit clear. Only the bench's scenarios can show the byte content and order on the bus, the packing of received bytes, the acknowledge pattern on reads, 10-bit addressing, NACK aborts and the SCL high time. For these, a target model on the bench's side of the open-drain lines sweeps every length from 1 to 8 in both directions.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
   localparam int unsigned BUS_W     = 32;
   localparam int unsigned MAX_BYTES = 8;
   localparam int unsigned IDX_W     = $clog2(MAX_BYTES);

   // register word indexes
   localparam logic [3:0] A_TXLO  = 4'd0;
   localparam logic [3:0] A_TXHI  = 4'd1;
   localparam logic [3:0] A_RXLO  = 4'd2;
   localparam logic [3:0] A_RXHI  = 4'd3;
   localparam logic [3:0] A_CTRL  = 4'd4;
   localparam logic [3:0] A_STAT  = 4'd5;
   localparam logic [3:0] A_CAUSE = 4'd6;
   localparam logic [3:0] A_MASK  = 4'd7;
   localparam logic [3:0] A_TIME  = 4'd8;

   // control word bit positions
   localparam int unsigned C_RD   = 1;
   localparam int unsigned C_ADDR = 2;
   localparam int unsigned C_TEN  = 12;
   localparam int unsigned C_TXSZ = 13;
   localparam int unsigned C_RXSZ = 16;
   localparam int unsigned C_GO   = 19;
   localparam int unsigned C_USED = 20;

   typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BITS, PH_STOP} phase_e;

   typedef struct packed {
      logic       ten;
      logic       rd;
      logic [9:0] addr;
      logic [2:0] txm1;
      logic [2:0] rxm1;
   } job_t;
endpackage

// File: rtl/i2cx_regs.sv
module i2cx_regs
   import i2cx_pkg::*;
#(
   parameter int unsigned TIMING_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [3:0]          bus_addr,
   input  logic                bus_we,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   input  logic                busy,
   input  logic                done,
   input  logic                done_err,
   input  logic                rx_we,
   input  logic [IDX_W-1:0]    rx_idx,
   input  logic [7:0]          rx_byte,
   output logic                start,
   output job_t                job,
   output logic [8*MAX_BYTES-1:0] tx_bytes,
   output logic [TIMING_W-1:0] quarter_cfg,
   output logic [C_USED-1:0]   ctrl_q,
   output logic                cause_q,
   output logic                mask_q,
   output logic                irq
);
   localparam int unsigned DW = 8*MAX_BYTES;

   if (TIMING_W < 2 || TIMING_W > BUS_W) begin : g_bad_timing_w
      $error("i2cx_regs: TIMING_W out of range");
   end

   logic [DW-1:0]       tx_q;
   logic [DW-1:0]       rx_q;
   logic                err_q;
   logic [TIMING_W-1:0] time_q;

   logic wr_txlo, wr_txhi, wr_ctrl, wr_cause, wr_mask, wr_time;

   always_comb begin
      wr_txlo  = bus_we && (bus_addr == A_TXLO);
      wr_txhi  = bus_we && (bus_addr == A_TXHI);
      wr_ctrl  = bus_we && (bus_addr == A_CTRL);
      wr_cause = bus_we && (bus_addr == A_CAUSE);
      wr_mask  = bus_we && (bus_addr == A_MASK);
      wr_time  = bus_we && (bus_addr == A_TIME);
   end

   assign start    = wr_ctrl && bus_wdata[C_GO] && !busy;
   assign job.ten  = bus_wdata[C_TEN];
   assign job.rd   = bus_wdata[C_RD];
   assign job.addr = bus_wdata[C_ADDR +: 10];
   assign job.txm1 = bus_wdata[C_TXSZ +: 3];
   assign job.rxm1 = bus_wdata[C_RXSZ +: 3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '0;
         rx_q    <= '0;
         ctrl_q  <= '0;
         err_q   <= 1'b0;
         cause_q <= 1'b0;
         mask_q  <= 1'b0;
         time_q  <= '0;
      end else begin
         if (wr_txlo && !busy) tx_q[BUS_W-1:0]  <= bus_wdata;
         if (wr_txhi && !busy) tx_q[DW-1:BUS_W] <= bus_wdata;
         if (wr_ctrl && !busy) ctrl_q <= bus_wdata[C_USED-1:0];
         if (start)      rx_q <= '0;
         else if (rx_we) rx_q[rx_idx*8 +: 8] <= rx_byte;
         if (start)     err_q <= 1'b0;
         else if (done) err_q <= done_err;
         if (done)          cause_q <= 1'b1;
         else if (wr_cause) cause_q <= bus_wdata[0];
         if (wr_mask) mask_q <= bus_wdata[0];
         if (wr_time) time_q <= bus_wdata[TIMING_W-1:0];
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_TXLO:  bus_rdata = tx_q[BUS_W-1:0];
         A_TXHI:  bus_rdata = tx_q[DW-1:BUS_W];
         A_RXLO:  bus_rdata = rx_q[BUS_W-1:0];
         A_RXHI:  bus_rdata = rx_q[DW-1:BUS_W];
         A_CTRL:  bus_rdata = BUS_W'(ctrl_q);
         A_STAT:  bus_rdata = BUS_W'(err_q);
         A_CAUSE: bus_rdata = BUS_W'(cause_q);
         A_MASK:  bus_rdata = BUS_W'(mask_q);
         A_TIME:  bus_rdata = BUS_W'(time_q);
         default: bus_rdata = '0;
      endcase
   end

   assign tx_bytes    = tx_q;
   assign quarter_cfg = time_q;
   assign irq         = cause_q & mask_q;
endmodule

// File: rtl/i2cx_qtick.sv
module i2cx_qtick #(
   parameter int unsigned TIMING_W    = 16,
   parameter int unsigned DEF_QUARTER = 125
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [TIMING_W-1:0] cfg,
   output logic                tick
);
   localparam logic [TIMING_W-1:0] DEF_Q = TIMING_W'(DEF_QUARTER);

   if (DEF_QUARTER < 1 || DEF_QUARTER >= (64'd1 << TIMING_W)) begin : g_bad_quarter
      $error("i2cx_qtick: DEF_QUARTER must fit TIMING_W and be nonzero");
   end

   logic [TIMING_W-1:0] cnt;
   logic [TIMING_W-1:0] lim;

   assign lim  = ((cfg == '0) ? DEF_Q : cfg) - 1'b1;
   assign tick = run && (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/i2cx_seq.sv
module i2cx_seq
   import i2cx_pkg::*;
#(
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  job_t                   job,
   input  logic [8*MAX_BYTES-1:0] tx_bytes,
   input  logic                   tick,
   input  logic                   sda_in,
   output logic                   busy,
   output logic                   in_bits,
   output logic                   scl_low,
   output logic                   sda_low,
   output logic                   done,
   output logic                   done_err,
   output logic                   rx_we,
   output logic [IDX_W-1:0]       rx_idx,
   output logic [7:0]             rx_byte
);
   localparam int unsigned BW = 4;    // byte index width, holds up to 2+MAX_BYTES
   localparam logic [3:0]  ACK_SLOT = 4'd8;

   phase_e        ph;
   logic [1:0]    q;
   job_t          job_q;
   logic [BW-1:0] bidx;
   logic [3:0]    slot;
   logic [7:0]    sh;
   logic          nack;
   logic          err;

   logic          ten;
   logic [BW-1:0] nab, ndata, last_b;
   logic          is_addr, rx_phase, last_byte;
   logic [7:0]    tx_byte, addr_byte;
   logic [2:0]    bitpos;

   // address-mode variant chosen at elaboration
   if (TEN_BIT_EN) begin : g_ten
      assign ten = job_q.ten;
      always_comb begin
         if (!ten)           addr_byte = {job_q.addr[6:0], job_q.rd};
         else if (bidx == 0) addr_byte = {5'b11110, job_q.addr[9:8], job_q.rd};
         else                addr_byte = job_q.addr[7:0];
      end
   end else begin : g_seven
      assign ten       = 1'b0;
      assign addr_byte = {job_q.addr[6:0], job_q.rd};
   end

   always_comb begin
      nab       = ten ? BW'(2) : BW'(1);
      ndata     = (job_q.rd ? BW'(job_q.rxm1) : BW'(job_q.txm1)) + BW'(1);
      last_b    = nab + ndata - BW'(1);
      is_addr   = bidx < nab;
      rx_phase  = !is_addr && job_q.rd;
      last_byte = bidx == last_b;
      rx_idx    = IDX_W'(bidx - nab);
      tx_byte   = is_addr ? addr_byte : tx_bytes[rx_idx*8 +: 8];
      bitpos    = 3'(4'd7 - slot);
   end

   // line drivers
   always_comb begin
      scl_low = 1'b0;
      sda_low = 1'b0;
      unique case (ph)
         PH_START: begin
            scl_low = q[1];
            sda_low = (q != 2'd0);
         end
         PH_BITS: begin
            scl_low = (q == 2'd0) || (q == 2'd3);
            if (slot < ACK_SLOT) sda_low = !rx_phase && !tx_byte[bitpos];
            else                 sda_low = rx_phase && !last_byte;
         end
         PH_STOP: begin
            scl_low = (q == 2'd0);
            sda_low = !q[1];
         end
         default: ;
      endcase
   end

   assign busy     = (ph != PH_IDLE);
   assign in_bits  = (ph == PH_BITS);
   assign done     = tick && (ph == PH_STOP) && (q == 2'd3);
   assign done_err = err;
   assign rx_we    = tick && in_bits && (q == 2'd3) && (slot == ACK_SLOT) && rx_phase;
   assign rx_byte  = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         q     <= '0;
         job_q <= '0;
         bidx  <= '0;
         slot  <= '0;
         sh    <= '0;
         nack  <= 1'b0;
         err   <= 1'b0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               if (start) begin
                  ph    <= PH_START;
                  q     <= '0;
                  job_q <= job;
                  err   <= 1'b0;
                  nack  <= 1'b0;
               end
            end
            PH_START: begin
               if (tick) begin
                  q <= q + 1'b1;
                  if (q == 2'd3) begin
                     ph   <= PH_BITS;
                     bidx <= '0;
                     slot <= '0;
                  end
               end
            end
            PH_BITS: begin
               if (tick) begin
                  q <= q + 1'b1;
                  if (q == 2'd1) begin
                     if (slot < ACK_SLOT && rx_phase) sh <= {sh[6:0], sda_in};
                     if (slot == ACK_SLOT && !rx_phase) nack <= sda_in;
                  end
                  if (q == 2'd3) begin
                     if (slot == ACK_SLOT) begin
                        slot <= '0;
                        if (!rx_phase && nack) begin
                           err <= 1'b1;
                           ph  <= PH_STOP;
                        end else if (last_byte) begin
                           ph <= PH_STOP;
                        end else begin
                           bidx <= bidx + 1'b1;
                        end
                     end else begin
                        slot <= slot + 1'b1;
                     end
                  end
               end
            end
            PH_STOP: begin
               if (tick) begin
                  q <= q + 1'b1;
                  if (q == 2'd3) ph <= PH_IDLE;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2c_xfer_engine.sv
module i2c_xfer_engine
   import i2cx_pkg::*;
#(
   parameter int unsigned TIMING_W    = 16,
   parameter int unsigned DEF_QUARTER = 125,
   parameter bit          TEN_BIT_EN  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  reg_addr,
   input  logic        reg_we,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq,
   output logic        scl_drive_low,
   output logic        sda_drive_low,
   input  logic        sda_in
);
   localparam int unsigned DW = 8*MAX_BYTES;

   logic                busy, in_bits, done, done_err, rx_we, start, tick;
   logic [IDX_W-1:0]    rx_idx;
   logic [7:0]          rx_byte;
   job_t                job;
   logic [DW-1:0]       tx_bytes;
   logic [TIMING_W-1:0] quarter_cfg;
   logic [C_USED-1:0]   ctrl_q;
   logic                cause_q, mask_q;

   i2cx_regs #(.TIMING_W(TIMING_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(reg_addr), .bus_we(reg_we), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
      .busy(busy), .done(done), .done_err(done_err),
      .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
      .start(start), .job(job), .tx_bytes(tx_bytes), .quarter_cfg(quarter_cfg),
      .ctrl_q(ctrl_q), .cause_q(cause_q), .mask_q(mask_q), .irq(irq)
   );

   i2cx_qtick #(.TIMING_W(TIMING_W), .DEF_QUARTER(DEF_QUARTER)) u_qtick (
      .clk(clk), .rst_n(rst_n), .run(busy), .cfg(quarter_cfg), .tick(tick)
   );

   i2cx_seq #(.TEN_BIT_EN(TEN_BIT_EN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .job(job), .tx_bytes(tx_bytes),
      .tick(tick), .sda_in(sda_in), .busy(busy), .in_bits(in_bits),
      .scl_low(scl_drive_low), .sda_low(sda_drive_low),
      .done(done), .done_err(done_err),
      .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
   );
endmodule

// File: rtl/i2cx_chk.sv
module i2cx_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        in_bits,
   input logic        scl_low,
   input logic        sda_low,
   input logic [19:0] ctrl_q,
   input logic        done,
   input logic        cause_q,
   input logic        mask_q,
   input logic        irq
);
   // R10: lines released while idle
   p_bus_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_low && !sda_low));

   // R10: SDA steady while SCL high inside bit slots
   p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_bits && $past(in_bits) && !scl_low && !$past(scl_low)) |-> $stable(sda_low));

   // R8: control frozen during a transfer
   p_ctrl_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ctrl_q));

   // R7: completion leaves the cause bit set
   p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cause_q);

   // R7: interrupt only with the mask bit set
   p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> mask_q);

   // R3: completion only from an active transfer
   p_done_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
endmodule

bind i2c_xfer_engine i2cx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .in_bits(in_bits),
   .scl_low(scl_drive_low), .sda_low(sda_drive_low), .ctrl_q(ctrl_q),
   .done(done), .cause_q(cause_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/i2c_xfer_engine_tb_top.sv
module i2c_xfer_engine_tb_top;
   localparam int Q = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, scl_drive_low, sda_drive_low;
   logic        slv_low = 1'b0;
   wire         scl_bus = !scl_drive_low;
   wire         sda_bus = !(sda_drive_low || slv_low);

   always #2 clk = ~clk;

   i2c_xfer_engine #(.TIMING_W(16), .DEF_QUARTER(Q), .TEN_BIT_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .sda_in(sda_bus)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;

   // target model state
   int         k = 0, bcnt = 0, nab_s = 1, starts = 0, stops = 0, stop_bcnt = 0;
   int         nack_at = -1, rd_len = 0, hi_run = 0, hi_last = 0;
   bit         is_rd_s = 0, prev_scl = 1, prev_sda = 1, irq_seen = 0;
   logic [7:0] sh = '0;
   logic [7:0] cap [0:15];
   logic       mack [0:15];
   logic [7:0] rd_src [0:7];

   function automatic bit master_sent(int b);
      return (b < nab_s) || !is_rd_s;
   endfunction

   always @(posedge clk) begin : target
      bit sn, dn;
      int di;
      sn = scl_bus; dn = sda_bus;
      if (irq) irq_seen = 1;
      if (sn) hi_run++;
      else begin
         if (prev_scl) hi_last = hi_run;
         hi_run = 0;
      end
      if (sn && prev_scl && prev_sda && !dn) begin
         starts++; k = 0; bcnt = 0; nab_s = 1; is_rd_s = 0; slv_low <= 1'b0;
      end else if (sn && prev_scl && !prev_sda && dn) begin
         stops++; stop_bcnt = bcnt; slv_low <= 1'b0;
      end else if (sn && !prev_scl) begin
         if (k < 8) sh = {sh[6:0], dn};
         else if (!master_sent(bcnt)) mack[bcnt & 15] = dn;
         k++;
         if (k == 8) begin
            cap[bcnt & 15] = sh;
            if (bcnt == 0) begin
               is_rd_s = sh[0];
               nab_s = (sh[7:3] == 5'b11110) ? 2 : 1;
            end
         end
      end else if (!sn && prev_scl) begin
         if (k == 9) begin k = 0; bcnt++; end
         di = bcnt - nab_s;
         if (k < 8 && !master_sent(bcnt) && di >= 0 && di < rd_len)
            slv_low <= !rd_src[di][7-k];
         else if (k == 8 && master_sent(bcnt) && bcnt != nack_at)
            slv_low <= 1'b1;
         else
            slv_low <= 1'b0;
      end
      prev_scl = sn; prev_sda = dn;
   end

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] v);
      @(negedge clk); reg_addr = a; #1 v = reg_rdata;
   endtask

   task automatic wait_done();
      logic [31:0] v;
      v = '0;
      while (!v[0]) rd(4'd6, v);
   endtask

   task automatic ack_clear();
      wr(4'd6, 32'h0); wr(4'd4, 32'h0);
   endtask

   function automatic logic [7:0] pat(int len, int i);
      return 8'((len*37 + i*11 + 5) & 255);
   endfunction

   function automatic logic [31:0] ctl(bit rdb, bit ten, int addr, int len);
      logic [31:0] c;
      c = 32'h0008_0000 | (32'(addr) << 2) | (ten ? 32'h1000 : 32'h0);
      if (rdb) c = c | 32'h2 | (32'(len-1) << 16);
      else     c = c | 32'h1 | (32'(len-1) << 13);
      return c;
   endfunction

   task automatic do_write(int len, bit ten, int addr, int nk, output int s0);
      logic [31:0] lo, hi;
      lo = '0; hi = '0;
      for (int i = 0; i < len; i++) begin
         if (i < 4) lo[8*i +: 8] = pat(len, i);
         else       hi[8*(i-4) +: 8] = pat(len, i);
      end
      nack_at = nk; rd_len = 0; s0 = starts;
      wr(4'd0, lo); wr(4'd1, hi);
      wr(4'd4, ctl(0, ten, addr, len));
      wait_done();
   endtask

   task automatic do_read(int len, bit ten, int addr);
      for (int i = 0; i < 8; i++) rd_src[i] = pat(len + 9, i);
      nack_at = -1; rd_len = len;
      wr(4'd4, ctl(1, ten, addr, len));
      wait_done();
   endtask

   task automatic check_rx(string req, int len);
      logic [31:0] v, elo, ehi;
      elo = '0; ehi = '0;
      for (int i = 0; i < len; i++) begin
         if (i < 4) elo[8*i +: 8] = pat(len + 9, i);
         else       ehi[8*(i-4) +: 8] = pat(len + 9, i);
      end
      rd(4'd2, v); check(req, "rx low word", v, elo);
      rd(4'd3, v); check(req, "rx high word", v, ehi);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int s0, nab;
      for (int i = 0; i < 16; i++) begin cap[i] = '0; mack[i] = 1'b0; end
      for (int i = 0; i < 8; i++) rd_src[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 9; a++) begin
         rd(4'(a), v); check("R1", $sformatf("reg %0d after reset", a), v, 32'h0);
      end
      check("R1", "irq after reset", 32'(irq), 32'h0);
      check("R1", "lines released", {30'h0, scl_drive_low, sda_drive_low}, 32'h0);

      // R2: readback of writable words
      wr(4'd0, 32'hDEAD_BEEF); rd(4'd0, v); check("R2", "tx low readback", v, 32'hDEAD_BEEF);
      wr(4'd1, 32'h1234_5678); rd(4'd1, v); check("R2", "tx high readback", v, 32'h1234_5678);
      wr(4'd8, 32'h0000_0000); rd(4'd8, v); check("R2", "timing readback", v, 32'h0);
      wr(4'd4, 32'hFFF0_0003); rd(4'd4, v); check("R2", "ctrl readback bits 19:0", v, 32'h0000_0003);
      wr(4'd4, 32'h0);
      wr(4'd7, 32'h1); rd(4'd7, v); check("R2", "mask readback", v, 32'h1);

      // R3: write sweep over all lengths
      for (int len = 1; len <= 8; len++) begin
         do_write(len, 0, 7'h50 + len, -1, s0);
         check("R3", "one START", 32'(starts - s0), 32'h1);
         check("R3", "bytes on bus", 32'(stop_bcnt), 32'(1 + len));
         check("R3", "address byte", 32'(cap[0]), 32'({7'(7'h50 + len), 1'b0}));
         for (int i = 0; i < len; i++)
            check("R3", $sformatf("len %0d data byte %0d", len, i), 32'(cap[1+i]), 32'(pat(len, i)));
         rd(4'd5, v); check("R6", "status clean on write", v, 32'h0);
         check("R7", "irq with mask set", 32'(irq), 32'h1);
         ack_clear();
         check("R7", "irq cleared by cause write", 32'(irq), 32'h0);
      end

      // R4: read sweep over all lengths
      for (int len = 1; len <= 8; len++) begin
         do_read(len, 0, 7'h21 + len);
         check("R4", "address byte", 32'(cap[0]), 32'({7'(7'h21 + len), 1'b1}));
         check("R4", "bytes on bus", 32'(stop_bcnt), 32'(1 + len));
         for (int i = 0; i < len; i++)
            check("R4", $sformatf("len %0d master ack byte %0d", len, i),
                  32'(mack[1+i]), 32'(i == len - 1));
         check_rx("R4", len);
         rd(4'd5, v); check("R6", "status clean on read", v, 32'h0);
         ack_clear();
      end
      check("R9", "SCL high time default", 32'(hi_last), 32'(2*Q));

      // R5: 10-bit write and read
      do_write(3, 1, 10'h2A5, -1, s0);
      check("R5", "10-bit first byte write", 32'(cap[0]), 32'hF4);
      check("R5", "10-bit second byte", 32'(cap[1]), 32'hA5);
      for (int i = 0; i < 3; i++)
         check("R5", "10-bit data byte", 32'(cap[2+i]), 32'(pat(3, i)));
      ack_clear();
      do_read(2, 1, 10'h1C3);
      check("R5", "10-bit first byte read", 32'(cap[0]), 32'hF3);
      check("R5", "10-bit second byte read", 32'(cap[1]), 32'hC3);
      check_rx("R5", 2);
      ack_clear();

      // R6: NACK on address, then on a data byte
      do_write(4, 0, 7'h33, 0, s0);
      rd(4'd5, v); check("R6", "status after address NACK", v, 32'h1);
      check("R6", "stop after address byte", 32'(stop_bcnt), 32'h1);
      ack_clear();
      do_write(6, 0, 7'h34, 3, s0);
      rd(4'd5, v); check("R6", "status after data NACK", v, 32'h1);
      check("R6", "stop after nacked data byte", 32'(stop_bcnt), 32'h4);
      ack_clear();
      do_write(2, 0, 7'h35, -1, s0);
      rd(4'd5, v); check("R6", "status cleared by next clean transfer", v, 32'h0);
      ack_clear();

      // R7: masked completion
      wr(4'd7, 32'h0); irq_seen = 0;
      do_write(1, 0, 7'h11, -1, s0);
      check("R7", "irq stays low when masked", 32'(irq_seen), 32'h0);
      wr(4'd7, 32'h1);
      check("R7", "irq once mask set", 32'(irq), 32'h1);
      ack_clear();
      rd(4'd6, v); check("R7", "cause cleared", v, 32'h0);

      // R8: writes while busy are ignored
      s0 = starts;
      wr(4'd0, 32'h0000_00A1);
      wr(4'd4, ctl(0, 0, 7'h22, 1));
      repeat (5) @(negedge clk);
      wr(4'd4, ctl(1, 0, 7'h44, 8));
      wr(4'd0, 32'h0000_00FF);
      rd(4'd4, v); check("R8", "ctrl unchanged while busy", v, ctl(0, 0, 7'h22, 1));
      rd(4'd0, v); check("R8", "tx unchanged while busy", v, 32'h0000_00A1);
      wait_done();
      repeat (200) @(negedge clk);
      check("R8", "single transfer", 32'(starts - s0), 32'h1);
      check("R8", "sent byte kept", 32'(cap[1]), 32'hA1);
      ack_clear();

      // R9: programmed quarter length
      wr(4'd8, 32'd5);
      do_read(1, 0, 7'h0F);
      check("R9", "SCL high time programmed", 32'(hi_last), 32'd10);
      check_rx("R9", 1);
      ack_clear();

      nab = 0;
      repeat (20) @(negedge clk);
      check("R10", "lines released after transfers", {30'h0, scl_drive_low, sda_drive_low}, 32'(nab));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule